// File: doc/BRIEF.md
# Masked-Write PHY Configuration Registers

This block holds the static configuration of a storage-interface PHY in a small bank of 32-bit words. The words sit at word-aligned byte offsets on a simple valid/write/address/data request port. A write never stores its upper 16 bits. Instead, bit x+16 of the write data decides whether bit x of the addressed word may take the new value. Software can therefore change one field, such as the DLL enable, with a single write, without first reading the word back.

The stored fields drive the PHY directly through dedicated outputs:

- operating frequency band
- pad drive strength
- output tap delay enable and tap delay amount
- power-down release
- DLL enable

One further offset is read-only. A read there returns the current levels of two PHY status inputs, calibration complete and DLL locked. The analog PHY and any bus bridge in front of the port are outside this block.

Top module: `phy_cfg_regbank`

## Requirements
- R1: After synchronous reset, every control word is zero except that the tap delay amount (word 0x00, bits 10:7) is 4. The outputs are therefore freq_sel=0, tap_dly_en=0, tap_dly_sel=4, pwr_release=0, dll_en=0 and drive_sel=0, and word 0x00 reads 0x00000200.
- R2: On a write to a control word, lower bit x is loaded from write data bit x only when write data bit x+16 is 1. All other lower bits keep their value.
- R3: A read of a control word returns zero in bits 31:16 and the stored 16-bit value in bits 15:0.
- R4: Word 0x00 carries the frequency band in bits 13:12 (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz). It carries the tap delay enable in bit 11 and the tap delay amount in bits 10:7. These bits drive freq_sel, tap_dly_en and tap_dly_sel.
- R5: Word 0x18 carries the power-down release in bit 0, the DLL enable in bit 1 and the drive-strength code in bits 6:4 (0 = 50, 1 = 33, 2 = 66, 3 = 100, 4 = 40 ohm). These bits drive pwr_release, dll_en and drive_sel.
- R6: A read of offset 0x20 returns stat_cal_done in bit 6 and stat_dll_ready in bit 5, sampled at the request edge. All other bits read zero.
- R7: A write to offset 0x20 changes no stored bit and no output.
- R8: A write to an offset that is not a control word has no effect, and a read of it returns zero. This covers 0x1C, anything above 0x20, and any offset with bits 1:0 nonzero.
- R9: A write updates the outputs at the clock edge that accepts it. Read data appears on rd_data after the edge that accepts the read, and holds until the next accepted read.
- R10: Words 0x04 through 0x14 are plain 16-bit masked storage. Writes to them leave words 0x00 and 0x18 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write enables (31:16) and data (15:0) |
| rd_data | output | 32 | Registered read result |
| stat_cal_done | input | 1 | Calibration complete from the PHY |
| stat_dll_ready | input | 1 | DLL locked from the PHY |
| freq_sel | output | 2 | Frequency band code |
| tap_dly_en | output | 1 | Output tap delay enable |
| tap_dly_sel | output | 4 | Output tap delay amount |
| pwr_release | output | 1 | Release PHY power-down |
| dll_en | output | 1 | DLL enable |
| drive_sel | output | 3 | Drive-strength code |

## Verification
The bench builds the block with its default parameters: seven control words, an 8-bit offset, status at 0x20 and a tap delay reset of 4. With these values the hole at 0x1C, the first out-of-range offset 0x24 and misaligned offsets are all reachable on the port. The defaults also put the reset value of a field in the middle of a word, so a partial-mask write can show that its neighbours survive. Status reads are repeated with different input levels to show that the result follows the pins and is not held in storage.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    // field positions inside word 0x00
    localparam int FREQ_LSB   = 12;
    localparam int TAPEN_BIT  = 11;
    localparam int TAPSEL_LSB = 7;
    // field positions inside the power word
    localparam int PWR_BIT    = 0;
    localparam int DLLEN_BIT  = 1;
    localparam int DRIVE_LSB  = 4;
    // status bit positions
    localparam int CAL_BIT    = 6;
    localparam int DLLRDY_BIT = 5;

    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        logic [1:0] freq;
        logic       tap_en;
        logic [3:0] tap_sel;
        logic       pwr;
        logic       dll;
        logic [2:0] drive;
    } phy_fields_t;

    // lower half takes new data only where the upper half enables it
    function automatic half_t masked_merge(input half_t old, input logic [DATA_W-1:0] wd);
        half_t en;
        en = wd[DATA_W-1:HALF_W];
        return (old & ~en) | (wd[HALF_W-1:0] & en);
    endfunction

endpackage

// File: rtl/phy_cfg_decode.sv
module phy_cfg_decode #(
    parameter int ADDR_W     = 8,
    parameter int NUM_CTRL   = 7,
    parameter int STATUS_OFS = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] sel,
    output logic                is_status
);
    localparam int WIDX_W = ADDR_W - 2;

    logic aligned;
    assign aligned   = (addr[1:0] == 2'b00);
    assign is_status = (addr == ADDR_W'(STATUS_OFS));

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
        assign sel[i] = aligned && (addr[ADDR_W-1:2] == WIDX_W'(i));
    end
endmodule

// File: rtl/phy_cfg_wreg.sv
module phy_cfg_wreg
    import phy_cfg_pkg::*;
#(
    parameter logic [15:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output half_t             q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= masked_merge(q, wdata);
    end
endmodule

// File: rtl/phy_cfg_readmux.sv
module phy_cfg_readmux
    import phy_cfg_pkg::*;
#(
    parameter int NUM_CTRL = 7
) (
    input  half_t [NUM_CTRL-1:0] regs,
    input  logic  [NUM_CTRL-1:0] sel,
    input  logic                 is_status,
    input  logic                 cal_done,
    input  logic                 dll_ready,
    output logic  [DATA_W-1:0]   value
);
    always_comb begin
        value = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (sel[i]) value[HALF_W-1:0] = value[HALF_W-1:0] | regs[i];
        end
        if (is_status) begin
            value[CAL_BIT]    = cal_done;
            value[DLLRDY_BIT] = dll_ready;
        end
    end
endmodule

// File: rtl/phy_cfg_regbank.sv
module phy_cfg_regbank
    import phy_cfg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_CTRL   = 7,
    parameter int STATUS_OFS = 32,
    parameter int TAP_RST    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic              stat_cal_done,
    input  logic              stat_dll_ready,
    output logic [1:0]        freq_sel,
    output logic              tap_dly_en,
    output logic [3:0]        tap_dly_sel,
    output logic              pwr_release,
    output logic              dll_en,
    output logic [2:0]        drive_sel
);
    localparam int          CFG_IDX  = 0;
    localparam int          PWR_IDX  = NUM_CTRL - 1;
    localparam logic [15:0] CFG_RST  = 16'(TAP_RST) << TAPSEL_LSB;

    logic [NUM_CTRL-1:0] sel;
    logic                is_status;
    half_t [NUM_CTRL-1:0] regs;
    logic [DATA_W-1:0]   rd_value;
    logic                wr_acc, rd_acc;
    phy_fields_t         fields;

    assign wr_acc = req_valid &&  req_write;
    assign rd_acc = req_valid && !req_write;

    phy_cfg_decode #(
        .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STATUS_OFS(STATUS_OFS)
    ) u_dec (
        .addr(req_addr), .sel(sel), .is_status(is_status)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        phy_cfg_wreg #(
            .RST_VAL((i == CFG_IDX) ? CFG_RST : 16'h0000)
        ) u_reg (
            .clk(clk), .rst(rst), .we(wr_acc && sel[i]),
            .wdata(req_wdata), .q(regs[i])
        );
    end

    phy_cfg_readmux #(.NUM_CTRL(NUM_CTRL)) u_rmux (
        .regs(regs), .sel(sel), .is_status(is_status),
        .cal_done(stat_cal_done), .dll_ready(stat_dll_ready),
        .value(rd_value)
    );

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_acc) rd_data <= rd_value;
    end

    always_comb begin
        fields.freq    = regs[CFG_IDX][FREQ_LSB +: 2];
        fields.tap_en  = regs[CFG_IDX][TAPEN_BIT];
        fields.tap_sel = regs[CFG_IDX][TAPSEL_LSB +: 4];
        fields.pwr     = regs[PWR_IDX][PWR_BIT];
        fields.dll     = regs[PWR_IDX][DLLEN_BIT];
        fields.drive   = regs[PWR_IDX][DRIVE_LSB +: 3];
    end

    assign freq_sel    = fields.freq;
    assign tap_dly_en  = fields.tap_en;
    assign tap_dly_sel = fields.tap_sel;
    assign pwr_release = fields.pwr;
    assign dll_en      = fields.dll;
    assign drive_sel   = fields.drive;
endmodule

// File: rtl/phy_cfg_regbank_chk.sv
module phy_cfg_regbank_chk #(
    parameter int ADDR_W     = 8,
    parameter int NUM_CTRL   = 7,
    parameter int STATUS_OFS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rd_data,
    input logic              stat_cal_done,
    input logic              stat_dll_ready,
    input logic [1:0]        freq_sel,
    input logic [3:0]        tap_dly_sel,
    input logic              pwr_release,
    input logic              dll_en,
    input logic [2:0]        drive_sel
);
    localparam logic [ADDR_W-1:0] PWR_OFS = ADDR_W'((NUM_CTRL - 1) * 4);

    logic rd_req, wr_req, ctrl_hit, stat_hit;
    assign rd_req   = req_valid && !req_write;
    assign wr_req   = req_valid &&  req_write;
    assign ctrl_hit = (req_addr[1:0] == 2'b00) && (int'(req_addr[ADDR_W-1:2]) < NUM_CTRL);
    assign stat_hit = (req_addr == ADDR_W'(STATUS_OFS));

    assert_freq_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_req && req_addr == '0 && req_wdata[29:28] == 2'b00) |=> $stable(freq_sel));

    assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ctrl_hit) |=> (rd_data[31:16] == 16'h0000));

    assert_drive_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && req_addr == PWR_OFS && req_wdata[22:20] == 3'b111)
        |=> (drive_sel == $past(req_wdata[6:4])));

    assert_status_live_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && stat_hit)
        |=> (rd_data == ((32'(($past(stat_cal_done))) << 6) | (32'(($past(stat_dll_ready))) << 5))));

    assert_no_write_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (!(wr_req && ctrl_hit)) |=> ($stable(freq_sel) && $stable(tap_dly_sel)
            && $stable(pwr_release) && $stable(dll_en) && $stable(drive_sel)));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !ctrl_hit && !stat_hit) |=> (rd_data == 32'h0));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_req) |=> $stable(rd_data));
endmodule

bind phy_cfg_regbank phy_cfg_regbank_chk #(
    .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STATUS_OFS(STATUS_OFS)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .stat_cal_done(stat_cal_done), .stat_dll_ready(stat_dll_ready),
    .freq_sel(freq_sel), .tap_dly_sel(tap_dly_sel), .pwr_release(pwr_release),
    .dll_en(dll_en), .drive_sel(drive_sel)
);

// File: tb/phy_cfg_regbank_bench.sv
module phy_cfg_regbank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        stat_cal_done = 1'b0;
    logic        stat_dll_ready = 1'b0;
    logic [1:0]  freq_sel;
    logic        tap_dly_en;
    logic [3:0]  tap_dly_sel;
    logic        pwr_release;
    logic        dll_en;
    logic [2:0]  drive_sel;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    phy_cfg_regbank u_phy_cfg_regbank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .stat_cal_done(stat_cal_done), .stat_dll_ready(stat_dll_ready),
        .freq_sel(freq_sel), .tap_dly_en(tap_dly_en), .tap_dly_sel(tap_dly_sel),
        .pwr_release(pwr_release), .dll_en(dll_en), .drive_sel(drive_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {19'b0, freq_sel, tap_dly_en, tap_dly_sel, pwr_release, dll_en, drive_sel};
    endfunction

    function automatic logic [31:0] pack_outs(input logic [1:0] f, input logic te,
            input logic [3:0] ts, input logic p, input logic d, input logic [2:0] dr);
        return {19'b0, f, te, ts, p, d, dr};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 outputs", outs(), pack_outs(2'd0, 1'b0, 4'd4, 1'b0, 1'b0, 3'd0));
        check("R1 rd_data", rd_data, 32'h0);
        do_read(8'h00, v);
        check("R1 word0", v, 32'h0000_0200);
        do_read(8'h18, v);
        check("R1 word18", v, 32'h0);
    endtask

    task automatic t_masked();
        do_write(8'h00, 32'h3000_3000);
        check("R2 freq set", {30'b0, freq_sel}, 32'd3);
        check("R2 tap kept", {28'b0, tap_dly_sel}, 32'd4);
        do_write(8'h00, 32'h1000_0000);
        check("R2 one bit", {30'b0, freq_sel}, 32'd2);
        do_write(8'h00, 32'h0000_FFFF);
        check("R2 no enables", outs(), pack_outs(2'd2, 1'b0, 4'd4, 1'b0, 1'b0, 3'd0));
    endtask

    task automatic t_word0();
        logic [31:0] v;
        do_write(8'h00, 32'h0F80_0C80);
        check("R4 fields", outs(), pack_outs(2'd2, 1'b1, 4'd9, 1'b0, 1'b0, 3'd0));
        do_read(8'h00, v);
        check("R3 word0 read", v, 32'h0000_2C80);
        do_write(8'h00, 32'h3000_1000);
        check("R4 freq 50MHz", {30'b0, freq_sel}, 32'd1);
    endtask

    task automatic t_word18();
        logic [31:0] v;
        do_write(8'h18, 32'h0073_0043);
        check("R5 fields", outs(), pack_outs(2'd1, 1'b1, 4'd9, 1'b1, 1'b1, 3'd4));
        do_read(8'h18, v);
        check("R5 read", v, 32'h0000_0043);
        do_write(8'h18, 32'h0002_0000);
        check("R5 dll off only", outs(), pack_outs(2'd1, 1'b1, 4'd9, 1'b1, 1'b0, 3'd4));
    endtask

    task automatic t_plain();
        logic [31:0] v;
        do_write(8'h04, 32'hFFFF_A5A5);
        do_write(8'h14, 32'hFFFF_1234);
        do_write(8'h08, 32'h00FF_FFFF);
        do_read(8'h04, v);
        check("R10 word04", v, 32'h0000_A5A5);
        do_read(8'h14, v);
        check("R10 word14", v, 32'h0000_1234);
        do_read(8'h08, v);
        check("R10 word08", v, 32'h0000_00FF);
        check("R10 neighbours", outs(), pack_outs(2'd1, 1'b1, 4'd9, 1'b1, 1'b0, 3'd4));
    endtask

    task automatic t_status();
        logic [31:0] v;
        stat_cal_done = 1'b1; stat_dll_ready = 1'b0;
        do_read(8'h20, v);
        check("R6 cal only", v, 32'h0000_0040);
        stat_cal_done = 1'b0; stat_dll_ready = 1'b1;
        do_read(8'h20, v);
        check("R6 dll only", v, 32'h0000_0020);
        stat_cal_done = 1'b1;
        do_read(8'h20, v);
        check("R6 both", v, 32'h0000_0060);
        do_write(8'h20, 32'hFFFF_FFFF);
        check("R7 outputs", outs(), pack_outs(2'd1, 1'b1, 4'd9, 1'b1, 1'b0, 3'd4));
        stat_cal_done = 1'b0; stat_dll_ready = 1'b0;
        do_read(8'h20, v);
        check("R7 status stays live", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_write(8'h1C, 32'hFFFF_FFFF);
        do_write(8'h24, 32'hFFFF_FFFF);
        do_write(8'h01, 32'hFFFF_0000);
        do_write(8'h1A, 32'hFFFF_0000);
        check("R8 outputs", outs(), pack_outs(2'd1, 1'b1, 4'd9, 1'b1, 1'b0, 3'd4));
        do_read(8'h00, v);
        check("R8 word0 kept", v, 32'h0000_1C80);
        do_read(8'h1C, v);
        check("R8 read 1C", v, 32'h0);
        do_read(8'h06, v);
        check("R8 misaligned read", v, 32'h0);
        do_read(8'h24, v);
        check("R8 read 24", v, 32'h0);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        do_read(8'h04, v);
        repeat (3) @(negedge clk);
        check("R9 rd hold", rd_data, 32'h0000_A5A5);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h18; req_wdata = 32'h0001_0000;
        #1;
        check("R9 before edge", {31'b0, pwr_release}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 after edge", {31'b0, pwr_release}, 32'd0);
        check("R9 rd after write", rd_data, 32'h0000_A5A5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masked();
        t_word0();
        t_word18();
        t_plain();
        t_status();
        t_unmapped();
        t_timing();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule